// File: doc/BRIEF.md
# Lane-Aware Router Switch Allocator

This block decides, every clock, which input virtual channels of a network router may send a flit across the switch. Each output channel is split into several narrow lanes that can be powered down independently. An allocation resource is therefore one lane of one output port. The lane a flit must use is not chosen freely. It is fixed by the output virtual channel the flit already holds, through the static rule lane = output VC mod lane count. With this rule no input ever steers between lanes and no extra multiplexing is needed.

Every (port, lane) resource has its own round-robin arbiter over all input VCs. Grants, the granted lane index, and a per-resource "won" pulse are all registered, so they appear together one cycle after the request. A lane whose active bit is low is still arbitrated. A grant onto such a lane raises a wake pulse that the surrounding logic uses to power the lane and the downstream buffer back on.

Top module: `lane_sw_alloc`

## Requirements
- R1: A granted requester's lane index on `gnt_lane` equals its output VC modulo `NUM_LANE`. With the defaults (4 VCs, 2 lanes), VCs 0 and 2 use lane 0 and VCs 1 and 3 use lane 1.
- R2: Each resource grants at most one requester per cycle. Resource index = port*`NUM_LANE` + lane, and `lane_won` bit k is high exactly when resource k granted a requester.
- R3: Requester index = input*`NUM_VC` + VC. Among the contenders for one resource, the winner is the first requesting index after that resource's previous winner, searching cyclically upward.
- R4: A resource's round-robin position moves only when that resource grants. Cycles without a contender leave its order unchanged.
- R5: A requester whose valid bit is low is never granted, and each requester gets at most one grant per cycle.
- R6: Resources arbitrate independently. Requesters aimed at different (port, lane) pairs can all be granted in the same cycle.
- R7: The active bit of a lane does not affect arbitration. `lane_wake` bit k is high exactly when resource k granted while its `lane_active` bit was low in the request cycle.
- R8: All outputs are registered and follow the request cycle by one clock. The `gnt_lane` entry of a requester that was not granted reads 0.
- R9: While reset is asserted, every output is 0. After reset, the first winner of each resource is its lowest-indexed contender.
- R10: A configuration with more lanes than VCs is rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_IN*NUM_VC | Request valid, one bit per input VC |
| req_port | input | NUM_IN*NUM_VC x PW | Requested output port per input VC |
| req_ovc | input | NUM_IN*NUM_VC x VCW | Assigned output VC per input VC |
| lane_active | input | NUM_OUT*NUM_LANE | Power state of each output lane |
| gnt | output | NUM_IN*NUM_VC | Registered grant per input VC |
| gnt_lane | output | NUM_IN*NUM_VC x LW | Lane index of each grant |
| lane_won | output | NUM_OUT*NUM_LANE | Resource granted last cycle |
| lane_wake | output | NUM_OUT*NUM_LANE | Grant onto an inactive lane |

## Verification
The bench floods one (port, lane) pair from every VC and checks that the winner rotates through all requesters. A stuck or badly offset pointer shows up as a repeated winner or a skipped one. Idle gaps between bursts expose a pointer that advances without a grant. Requests that share a port but hold VCs of different parity catch a wrong VC-to-lane mapping, which would merge two lanes and starve one requester. Random power masks check that a wake is raised only for a win on a sleeping lane, and that no grant is held back because a lane is off.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  // width of an index into n items, never zero
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lsa_lane_map.sv
module lsa_lane_map #(
  parameter int NUM_VC   = 4,
  parameter int NUM_LANE = 2,
  localparam int VCW = lsa_pkg::idx_w(NUM_VC),
  localparam int LW  = lsa_pkg::idx_w(NUM_LANE)
) (
  input  logic [VCW-1:0] ovc,
  output logic [LW-1:0]  lane
);
  // R1: static map, lane = output VC mod lane count
  generate
    if (NUM_LANE == 1) begin : g_single
      logic unused_ovc;
      assign unused_ovc = ^ovc;
      assign lane = '0;
    end else if (NUM_LANE == NUM_VC) begin : g_ident
      assign lane = LW'(ovc);
    end else begin : g_mod
      assign lane = LW'(int'(ovc) % NUM_LANE);
    end
  endgenerate
endmodule

// File: rtl/lsa_rr_arb.sv
module lsa_rr_arb #(
  parameter int N = 12,
  localparam int IW = lsa_pkg::idx_w(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic          found;

  // search starts one past the last winner
  always_comb begin
    gnt   = '0;
    ptr_d = ptr_q;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      if (!found && req[(int'(ptr_q) + off) % N]) begin
        gnt[(int'(ptr_q) + off) % N] = 1'b1;
        ptr_d = IW'((int'(ptr_q) + off) % N);
        found = 1'b1;
      end
    end
  end

  // R4: pointer moves only when a grant is made
  assign ptr_en = |req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= IW'(N - 1);
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/lane_sw_alloc.sv
module lane_sw_alloc #(
  parameter int NUM_IN   = 3,
  parameter int NUM_VC   = 4,
  parameter int NUM_OUT  = 3,
  parameter int NUM_LANE = 2,
  localparam int NREQ = NUM_IN * NUM_VC,
  localparam int NRES = NUM_OUT * NUM_LANE,
  localparam int PW   = lsa_pkg::idx_w(NUM_OUT),
  localparam int VCW  = lsa_pkg::idx_w(NUM_VC),
  localparam int LW   = lsa_pkg::idx_w(NUM_LANE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ-1:0][PW-1:0]  req_port,
  input  logic [NREQ-1:0][VCW-1:0] req_ovc,
  input  logic [NRES-1:0]          lane_active,
  output logic [NREQ-1:0]          gnt,
  output logic [NREQ-1:0][LW-1:0]  gnt_lane,
  output logic [NRES-1:0]          lane_won,
  output logic [NRES-1:0]          lane_wake
);
  // R10: lanes may not outnumber VCs
  generate
    if (NUM_LANE > NUM_VC || NUM_LANE < 1) begin : g_bad_cfg
      $error("lane_sw_alloc: NUM_LANE must be between 1 and NUM_VC");
    end
  endgenerate

  logic [NREQ-1:0][LW-1:0] req_lane;
  logic [NRES-1:0][NREQ-1:0] match;
  logic [NRES-1:0][NREQ-1:0] arb_gnt;

  logic [NREQ-1:0]         gnt_d;
  logic [NREQ-1:0][LW-1:0] gnt_lane_d;
  logic [NRES-1:0]         won_d;
  logic [NRES-1:0]         wake_d;

  genvar r, k;
  generate
    for (r = 0; r < NREQ; r++) begin : g_map
      lsa_lane_map #(.NUM_VC(NUM_VC), .NUM_LANE(NUM_LANE)) u_map (
        .ovc  (req_ovc[r]),
        .lane (req_lane[r])
      );
    end
  endgenerate

  // route every request to the single resource it targets
  always_comb begin
    for (int s = 0; s < NRES; s++) begin
      for (int q = 0; q < NREQ; q++) begin
        match[s][q] = req_valid[q]
                   && (int'(req_port[q]) == s / NUM_LANE)
                   && (int'(req_lane[q]) == s % NUM_LANE);
      end
    end
  end

  generate
    for (k = 0; k < NRES; k++) begin : g_arb
      lsa_rr_arb #(.N(NREQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (match[k]),
        .gnt   (arb_gnt[k])
      );
    end
  endgenerate

  // collect arbiter results
  always_comb begin
    gnt_d      = '0;
    gnt_lane_d = '0;
    for (int s = 0; s < NRES; s++) begin
      won_d[s]  = |arb_gnt[s];
      wake_d[s] = (|arb_gnt[s]) && !lane_active[s];
      for (int q = 0; q < NREQ; q++) begin
        if (arb_gnt[s][q]) begin
          gnt_d[q]      = 1'b1;
          gnt_lane_d[q] = req_lane[q];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt       <= '0;
      gnt_lane  <= '0;
      lane_won  <= '0;
      lane_wake <= '0;
    end else begin
      gnt       <= gnt_d;
      gnt_lane  <= gnt_lane_d;
      lane_won  <= won_d;
      lane_wake <= wake_d;
    end
  end
endmodule

// File: rtl/lane_sw_alloc_chk.sv
module lane_sw_alloc_chk #(
  parameter int NUM_IN   = 3,
  parameter int NUM_VC   = 4,
  parameter int NUM_OUT  = 3,
  parameter int NUM_LANE = 2,
  localparam int NREQ = NUM_IN * NUM_VC,
  localparam int NRES = NUM_OUT * NUM_LANE,
  localparam int PW   = lsa_pkg::idx_w(NUM_OUT),
  localparam int VCW  = lsa_pkg::idx_w(NUM_VC),
  localparam int LW   = lsa_pkg::idx_w(NUM_LANE)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NREQ-1:0]          req_valid,
  input logic [NREQ-1:0][PW-1:0]  req_port,
  input logic [NREQ-1:0][VCW-1:0] req_ovc,
  input logic [NRES-1:0]          lane_active,
  input logic [NREQ-1:0]          gnt,
  input logic [NREQ-1:0][LW-1:0]  gnt_lane,
  input logic [NRES-1:0]          lane_won,
  input logic [NRES-1:0]          lane_wake
);
  logic unused_port;
  assign unused_port = ^req_port;

  AST_ONE_GNT_PER_RES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) == $countones(lane_won)); // R2

  genvar r, k;
  generate
    for (r = 0; r < NREQ; r++) begin : g_req
      AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[r] |-> $past(req_valid[r])); // R5
      AST_LANE_FROM_OVC: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[r] |-> (int'(gnt_lane[r]) == int'($past(req_ovc[r])) % NUM_LANE)); // R1
      AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt[r] |-> (gnt_lane[r] == '0)); // R8
    end
    for (k = 0; k < NRES; k++) begin : g_res
      AST_WAKE_ON_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        lane_wake[k] |-> (lane_won[k] && !$past(lane_active[k]))); // R7
      AST_WIN_WAKES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_won[k] && !$past(lane_active[k])) |-> lane_wake[k]); // R7
    end
  endgenerate
endmodule

bind lane_sw_alloc lane_sw_alloc_chk #(
  .NUM_IN(NUM_IN), .NUM_VC(NUM_VC), .NUM_OUT(NUM_OUT), .NUM_LANE(NUM_LANE)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
  .req_ovc(req_ovc), .lane_active(lane_active), .gnt(gnt),
  .gnt_lane(gnt_lane), .lane_won(lane_won), .lane_wake(lane_wake)
);

// File: tb/test_lane_sw_alloc.sv
module test_lane_sw_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3, NV = 4, NO = 3, NL = 2;
  localparam int NREQ = NI * NV, NRES = NO * NL;
  localparam int PW = 2, VCW = 2, LW = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NREQ-1:0]          req_valid;
  logic [NREQ-1:0][PW-1:0]  req_port;
  logic [NREQ-1:0][VCW-1:0] req_ovc;
  logic [NRES-1:0]          lane_active;
  logic [NREQ-1:0]          gnt;
  logic [NREQ-1:0][LW-1:0]  gnt_lane;
  logic [NRES-1:0]          lane_won;
  logic [NRES-1:0]          lane_wake;

  lane_sw_alloc #(.NUM_IN(NI), .NUM_VC(NV), .NUM_OUT(NO), .NUM_LANE(NL)) i_lane_sw_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_ovc(req_ovc), .lane_active(lane_active), .gnt(gnt),
    .gnt_lane(gnt_lane), .lane_won(lane_won), .lane_wake(lane_wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  string tag = "R9";
  bit done = 1'b0;

  // reference model state
  int ptr[NRES];
  logic [NREQ-1:0]         e_gnt;
  logic [NREQ-1:0][LW-1:0] e_lane;
  logic [NRES-1:0]         e_won;
  logic [NRES-1:0]         e_wake;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s (phase %s): actual %h expected %h", req, tag, act, exp);
    end
  endtask

  task automatic model();
    e_gnt = '0; e_lane = '0; e_won = '0; e_wake = '0;
    for (int s = 0; s < NRES; s++) begin
      int w;
      w = -1;
      for (int off = 1; off <= NREQ; off++) begin
        int q;
        q = (ptr[s] + off) % NREQ;
        if (w < 0 && req_valid[q] && int'(req_port[q]) == s / NL
            && int'(req_ovc[q]) % NL == s % NL) w = q;
      end
      if (w >= 0) begin
        e_gnt[w]  = 1'b1;
        e_lane[w] = LW'(s % NL);
        e_won[s]  = 1'b1;
        e_wake[s] = !lane_active[s];
        ptr[s]    = w;
      end
    end
  endtask

  // compare last cycle's results, then present the new request set
  task automatic step(input logic [NREQ-1:0] v, input logic [NREQ-1:0][PW-1:0] p,
                      input logic [NREQ-1:0][VCW-1:0] o, input logic [NRES-1:0] a);
    @(negedge clk);
    check("R3/R5 gnt", 64'(gnt), 64'(e_gnt));
    check("R1/R8 gnt_lane", 64'(gnt_lane), 64'(e_lane));
    check("R2 lane_won", 64'(lane_won), 64'(e_won));
    check("R7 lane_wake", 64'(lane_wake), 64'(e_wake));
    req_valid = v; req_port = p; req_ovc = o; lane_active = a;
    model();
  endtask

  function automatic logic [NREQ-1:0][PW-1:0] rnd_port();
    logic [NREQ-1:0][PW-1:0] p;
    for (int q = 0; q < NREQ; q++) p[q] = PW'($urandom_range(NO - 1));
    return p;
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [NREQ-1:0][PW-1:0]  p;
    logic [NREQ-1:0][VCW-1:0] o;
    rst_n = 1'b0;
    req_valid = '0; req_port = '0; req_ovc = '0; lane_active = '1;
    for (int s = 0; s < NRES; s++) ptr[s] = NREQ - 1;
    e_gnt = '0; e_lane = '0; e_won = '0; e_wake = '0;
    repeat (3) @(negedge clk);
    // R9: outputs idle in reset even with requests present
    req_valid = '1;
    @(negedge clk);
    check("R9 reset gnt", 64'(gnt), 64'd0);
    check("R9 reset won/wake", 64'({lane_won, lane_wake}), 64'd0);
    req_valid = '0;
    rst_n = 1'b1;

    // R3 + R9: every VC contends for port 0 lane 0, winner rotates from 0
    tag = "R3";
    for (int c = 0; c < NREQ + 3; c++) step('1, '0, '0, '1);
    // R4: idle gap, order must resume where it stopped
    tag = "R4";
    for (int c = 0; c < 3; c++) step('0, '0, '0, '1);
    for (int c = 0; c < 5; c++) step(12'b1010_0110_0101, '0, '0, '1);
    // R1: same port, lanes picked by VC parity (VC 0,2 -> lane 0; 1,3 -> lane 1)
    tag = "R1";
    for (int c = 0; c < 6; c++) begin
      for (int q = 0; q < NREQ; q++) o[q] = VCW'(q);
      step('1, '0, o, '1);
    end
    // R6: one requester per resource, all granted together
    tag = "R6";
    for (int q = 0; q < NREQ; q++) begin
      p[q] = PW'(q % NO);
      o[q] = VCW'((q / NO) % NV);
    end
    step(12'b0000_0011_1111, p, o, '1);
    step('0, '0, '0, '1);
    // R7: all lanes asleep, then a mixed mask
    tag = "R7";
    for (int c = 0; c < 4; c++) step('1, p, o, '0);
    for (int c = 0; c < 4; c++) step('1, p, o, 6'b101001);
    // R5: random traffic, valid bits sparse
    tag = "R5";
    for (int c = 0; c < 400; c++) begin
      for (int q = 0; q < NREQ; q++) o[q] = VCW'($urandom_range(NV - 1));
      step(NREQ'($urandom), rnd_port(), o, NRES'($urandom));
    end
    step('0, '0, '0, '1);
    step('0, '0, '0, '1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule